// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block turns one host request into the strobe and bus-control waveform for a single NAND flash bus cycle. A request is a command latch, an address latch, a data read or a data write, with write data and a lane-width flag. The sequencer runs the access through phases whose lengths are programmable, all counted in host clock cycles. An optional gap comes first. Then come setup, strobe and hold, with a data-bus tristate window at the start of a write.

The timing fields and the target bank sit in a small configuration store. The host loads it with a one-cycle load strobe, and the load takes effect only when no access is running. The NAND side is driven with per-bank active-low chip enables, the two latch qualifiers, active-low write and read strobes, a data output enable and output data. An active-low wait input from the flash stretches the strobe. Read data is captured when the read strobe ends and is returned with a one-cycle done pulse.

Top module: `nand_seq_top`

## Requirements
- R1: After reset the block is idle. `busy` and `done` are low, every `nand_ce_n` bit is high, both strobes are high, `nand_cle`/`nand_ale`/`nand_dq_oe` are low, and the configuration is all zero with bank 0.
- R2: A request is taken when `req_valid` is high while idle. `busy` rises in the next cycle and stays high for exactly gap + setup + strobe + hold cycles, and a chip enable is asserted in each of those cycles.
- R3: The setup phase lasts `cfg_setup`+1 cycles. The strobe starts once the gap and the setup phase have elapsed.
- R4: `req_kind` encodes 0 = command, 1 = address, 2 = read, 3 = write. The strobe phase lasts `cfg_strobe`+1 cycles when wait is high. Reads pulse `nand_re_n` low, all other kinds pulse `nand_we_n` low, and the two strobes are never low together.
- R5: The strobe phase does not end while `nand_wait_n` is low. It ends on the first cycle in which its count has expired and `nand_wait_n` is high.
- R6: The hold phase lasts `cfg_hold`+1 cycles after the strobe rises. Chip enable, latch qualifier and driven data stay unchanged through it.
- R7: On writes the data bus is left undriven for the first `cfg_hiz` cycles of the access, and 0 means no undriven period. Command and address cycles drive the bus from their first cycle, and reads never drive it.
- R8: `nand_cle` is high through setup, strobe and hold of a command access, and `nand_ale` likewise for an address access. Neither is high for reads, writes or gap cycles.
- R9: A read whose most recent preceding access was a command inserts `cfg_cle_gap`+1 gap cycles before setup. If that access was an address, it inserts `cfg_ale_gap`+1 cycles instead. After a read or a write no gap is inserted.
- R10: For reads, `nand_dq_in` is sampled on the last strobe cycle. `rd_data` and a single-cycle `done` are presented in the first hold cycle, and non-read accesses give no `done`.
- R11: When `req_wide` is 0 only the low byte is used. `nand_dq_out` bits above bit 7 are 0, and `rd_data` bits above bit 7 are 0.
- R12: Only the chip enable selected by the configured bank (0 to 3) goes low during an access. All chip enables are high while idle.
- R13: `cfg_load` while busy is ignored. The running access and the next one use the configuration that was held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; all phase counts are in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_kind | input | 2 | 0 command, 1 address, 2 read, 3 write |
| req_wdata | input | DATA_W | Command, address or write data |
| req_wide | input | 1 | 1 = full width, 0 = low byte only |
| cfg_load | input | 1 | Loads the configuration fields when idle |
| cfg_setup | input | TW | Setup length minus one |
| cfg_strobe | input | TW | Strobe length minus one |
| cfg_hold | input | TW | Hold length minus one |
| cfg_hiz | input | TW | Undriven cycles at the start of a write |
| cfg_cle_gap | input | GW | Command-to-read gap minus one |
| cfg_ale_gap | input | GW | Address-to-read gap minus one |
| cfg_bank | input | BANK_W | Target bank |
| busy | output | 1 | Access in progress |
| done | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Captured read data |
| nand_ce_n | output | BANKS | Active-low chip enables |
| nand_cle | output | 1 | Command latch qualifier |
| nand_ale | output | 1 | Address latch qualifier |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_wait_n | input | 1 | Active-low wait from the flash |
| nand_dq_in | input | DATA_W | Data bus from the flash |
| nand_dq_out | output | DATA_W | Data bus to the flash |
| nand_dq_oe | output | 1 | Data bus output enable |

## Verification
The assertions assume that `nand_wait_n` is eventually released. They also assume that requests are raised only while `busy` is low, since a request during an access is simply not taken. The stimulus holds wait low for a bounded number of cycles measured from acceptance, sometimes ending before the strobe and sometimes well past its programmed count. It issues each request only after `busy` has fallen. Configuration loads come either between accesses or, deliberately, in the middle of one to exercise the ignore rule.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        ACC_CMD   = 2'd0,
        ACC_ADDR  = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        LAT_NONE,
        LAT_CMD,
        LAT_ADDR
    } latch_e;

endpackage

// File: rtl/nand_seq_cfg.sv
module nand_seq_cfg #(
    parameter int TW     = 8,
    parameter int GW     = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              load,
    input  logic [TW-1:0]     setup_i,
    input  logic [TW-1:0]     strobe_i,
    input  logic [TW-1:0]     hold_i,
    input  logic [TW-1:0]     hiz_i,
    input  logic [GW-1:0]     cle_gap_i,
    input  logic [GW-1:0]     ale_gap_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [TW-1:0]     setup_o,
    output logic [TW-1:0]     strobe_o,
    output logic [TW-1:0]     hold_o,
    output logic [TW-1:0]     hiz_o,
    output logic [GW-1:0]     cle_gap_o,
    output logic [GW-1:0]     ale_gap_o,
    output logic [BANK_W-1:0] bank_o
);

    typedef struct packed {
        logic [TW-1:0]     setup;
        logic [TW-1:0]     strobe;
        logic [TW-1:0]     hold;
        logic [TW-1:0]     hiz;
        logic [GW-1:0]     cle_gap;
        logic [GW-1:0]     ale_gap;
        logic [BANK_W-1:0] bank;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load && idle) begin
            cfg_d.setup   = setup_i;
            cfg_d.strobe  = strobe_i;
            cfg_d.hold    = hold_i;
            cfg_d.hiz     = hiz_i;
            cfg_d.cle_gap = cle_gap_i;
            cfg_d.ale_gap = ale_gap_i;
            cfg_d.bank    = bank_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign setup_o   = cfg_q.setup;
    assign strobe_o  = cfg_q.strobe;
    assign hold_o    = cfg_q.hold;
    assign hiz_o     = cfg_q.hiz;
    assign cle_gap_o = cfg_q.cle_gap;
    assign ale_gap_o = cfg_q.ale_gap;
    assign bank_o    = cfg_q.bank;

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TW     = 8,
    parameter int GW     = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  acc_kind_e         req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_wide,
    input  logic [TW-1:0]     setup,
    input  logic [TW-1:0]     strobe,
    input  logic [TW-1:0]     hold,
    input  logic [TW-1:0]     hiz,
    input  logic [GW-1:0]     cle_gap,
    input  logic [GW-1:0]     ale_gap,
    input  logic [BANK_W-1:0] bank,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] dq_in,
    output phase_e            phase,
    output acc_kind_e         kind,
    output logic [DATA_W-1:0] wdata,
    output logic              wide,
    output logic [BANK_W-1:0] acc_bank,
    output logic              hiz_open,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    localparam int LANE_W = 8;
    localparam int PAD_W  = TW - GW;

    typedef struct packed {
        phase_e            phase;
        acc_kind_e         kind;
        logic [DATA_W-1:0] wdata;
        logic              wide;
        logic [BANK_W-1:0] bank;
        logic [TW-1:0]     cnt;
        logic [TW-1:0]     hiz_cnt;
        latch_e            last;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic [DATA_W-1:0] rd_lane;

    always_comb begin
        if (s_q.wide) begin
            rd_lane = dq_in;
        end else begin
            rd_lane = {{(DATA_W-LANE_W){1'b0}}, dq_in[LANE_W-1:0]};
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.hiz_cnt != '0) begin
            s_d.hiz_cnt = s_q.hiz_cnt - 1'b1;
        end
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.kind  = req_kind;
                    s_d.wdata = req_wdata;
                    s_d.wide  = req_wide;
                    s_d.bank  = bank;
                    s_d.hiz_cnt = (req_kind == ACC_WRITE) ? hiz : '0;
                    if (req_kind == ACC_READ && s_q.last == LAT_CMD) begin
                        s_d.phase = PH_GAP;
                        s_d.cnt   = {{PAD_W{1'b0}}, cle_gap};
                    end else if (req_kind == ACC_READ && s_q.last == LAT_ADDR) begin
                        s_d.phase = PH_GAP;
                        s_d.cnt   = {{PAD_W{1'b0}}, ale_gap};
                    end else begin
                        s_d.phase = PH_SETUP;
                        s_d.cnt   = setup;
                    end
                    case (req_kind)
                        ACC_CMD:  s_d.last = LAT_CMD;
                        ACC_ADDR: s_d.last = LAT_ADDR;
                        default:  s_d.last = LAT_NONE;
                    endcase
                end
            end
            PH_GAP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = setup;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = strobe;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (wait_n) begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = hold;
                    if (s_q.kind == ACC_READ) begin
                        s_d.rdata = rd_lane;
                        s_d.done  = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.kind  <= ACC_CMD;
            s_q.last  <= LAT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase    = s_q.phase;
    assign kind     = s_q.kind;
    assign wdata    = s_q.wdata;
    assign wide     = s_q.wide;
    assign acc_bank = s_q.bank;
    assign hiz_open = (s_q.hiz_cnt == '0);
    assign rd_data  = s_q.rdata;
    assign done     = s_q.done;

endmodule

// File: rtl/nand_seq_pins.sv
module nand_seq_pins
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANKS  = 4,
    parameter int BANK_W = 2
) (
    input  phase_e            phase,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wide,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic              hiz_open,
    output logic [BANKS-1:0]  ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);

    localparam int LANE_W = 8;

    logic active;
    logic latch_ph;
    logic strobe_ph;
    logic [DATA_W-1:0] lane_data;

    assign active    = (phase != PH_IDLE);
    assign latch_ph  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign strobe_ph = (phase == PH_STROBE);

    for (genvar b = 0; b < BANKS; b++) begin : g_ce
        assign ce_n[b] = !(active && (acc_bank == BANK_W'(b)));
    end

    assign cle   = latch_ph && (kind == ACC_CMD);
    assign ale   = latch_ph && (kind == ACC_ADDR);
    assign we_n  = !(strobe_ph && (kind != ACC_READ));
    assign re_n  = !(strobe_ph && (kind == ACC_READ));
    assign dq_oe = latch_ph && (kind != ACC_READ) && hiz_open;

    always_comb begin
        if (wide) begin
            lane_data = wdata;
        end else begin
            lane_data = {{(DATA_W-LANE_W){1'b0}}, wdata[LANE_W-1:0]};
        end
    end

    assign dq_out = dq_oe ? lane_data : '0;

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nand_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TW     = 8,
    parameter int GW     = 4,
    parameter int BANKS  = 4,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_wide,
    input  logic              cfg_load,
    input  logic [TW-1:0]     cfg_setup,
    input  logic [TW-1:0]     cfg_strobe,
    input  logic [TW-1:0]     cfg_hold,
    input  logic [TW-1:0]     cfg_hiz,
    input  logic [GW-1:0]     cfg_cle_gap,
    input  logic [GW-1:0]     cfg_ale_gap,
    input  logic [BANK_W-1:0] cfg_bank,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [BANKS-1:0]  nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    input  logic              nand_wait_n,
    input  logic [DATA_W-1:0] nand_dq_in,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe
);

    logic [TW-1:0]     t_setup, t_strobe, t_hold, t_hiz;
    logic [GW-1:0]     t_cle_gap, t_ale_gap;
    logic [BANK_W-1:0] t_bank;
    phase_e            phase;
    acc_kind_e         kind;
    logic [DATA_W-1:0] wdata;
    logic              wide;
    logic [BANK_W-1:0] acc_bank;
    logic              hiz_open;

    assign busy = (phase != PH_IDLE);

    nand_seq_cfg #(.TW(TW), .GW(GW), .BANK_W(BANK_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (!busy),
        .load      (cfg_load),
        .setup_i   (cfg_setup),
        .strobe_i  (cfg_strobe),
        .hold_i    (cfg_hold),
        .hiz_i     (cfg_hiz),
        .cle_gap_i (cfg_cle_gap),
        .ale_gap_i (cfg_ale_gap),
        .bank_i    (cfg_bank),
        .setup_o   (t_setup),
        .strobe_o  (t_strobe),
        .hold_o    (t_hold),
        .hiz_o     (t_hiz),
        .cle_gap_o (t_cle_gap),
        .ale_gap_o (t_ale_gap),
        .bank_o    (t_bank)
    );

    nand_seq_fsm #(.DATA_W(DATA_W), .TW(TW), .GW(GW), .BANK_W(BANK_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (acc_kind_e'(req_kind)),
        .req_wdata (req_wdata),
        .req_wide  (req_wide),
        .setup     (t_setup),
        .strobe    (t_strobe),
        .hold      (t_hold),
        .hiz       (t_hiz),
        .cle_gap   (t_cle_gap),
        .ale_gap   (t_ale_gap),
        .bank      (t_bank),
        .wait_n    (nand_wait_n),
        .dq_in     (nand_dq_in),
        .phase     (phase),
        .kind      (kind),
        .wdata     (wdata),
        .wide      (wide),
        .acc_bank  (acc_bank),
        .hiz_open  (hiz_open),
        .rd_data   (rd_data),
        .done      (done)
    );

    nand_seq_pins #(.DATA_W(DATA_W), .BANKS(BANKS), .BANK_W(BANK_W)) u_pins (
        .phase    (phase),
        .kind     (kind),
        .wdata    (wdata),
        .wide     (wide),
        .acc_bank (acc_bank),
        .hiz_open (hiz_open),
        .ce_n     (nand_ce_n),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_oe    (nand_dq_oe),
        .dq_out   (nand_dq_out)
    );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
    parameter int BANKS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [BANKS-1:0] ce_n,
    input logic             cle,
    input logic             ale,
    input logic             we_n,
    input logic             re_n,
    input logic             wait_n,
    input logic             dq_oe
);

    // R4: read and write strobes are never low together
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R2: exactly one chip enable while an access runs
    p_busy_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(~ce_n) == 1));

    // R12: all chip enables released while idle
    p_idle_ce_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&ce_n));

    // R8: latch qualifiers are mutually exclusive
    p_latch_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R5: a strobe with wait low continues into the next cycle
    p_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((!we_n || !re_n) && !wait_n) |=> (!we_n || !re_n));

    // R10: done lasts one cycle and only inside an access
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R7: the bus is never driven during a read strobe
    p_read_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

endmodule

bind nand_seq_top nand_seq_chk #(.BANKS(BANKS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .ce_n   (nand_ce_n),
    .cle    (nand_cle),
    .ale    (nand_ale),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .wait_n (nand_wait_n),
    .dq_oe  (nand_dq_oe)
);

// File: tb/nand_seq_top_test.sv
`timescale 1ns/1ps
module nand_seq_top_test;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_wide = 1'b0;
    logic          cfg_load = 1'b0;
    logic [7:0]    cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0, cfg_hiz = '0;
    logic [3:0]    cfg_cle_gap = '0, cfg_ale_gap = '0;
    logic [1:0]    cfg_bank = '0;
    logic          busy, done;
    logic [DW-1:0] rd_data;
    logic [3:0]    nand_ce_n;
    logic          nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic          nand_wait_n = 1'b1;
    logic [DW-1:0] nand_dq_in = '0;
    logic [DW-1:0] nand_dq_out;
    logic          nand_dq_oe;

    always #4 clk = ~clk;

    nand_seq_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .req_wide(req_wide), .cfg_load(cfg_load),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_hiz(cfg_hiz), .cfg_cle_gap(cfg_cle_gap), .cfg_ale_gap(cfg_ale_gap),
        .cfg_bank(cfg_bank), .busy(busy), .done(done), .rd_data(rd_data),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wait_n(nand_wait_n),
        .nand_dq_in(nand_dq_in), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model of the configuration and latch history
    int m_setup = 0, m_strb = 0, m_hold = 0, m_hiz = 0, m_clr = 0, m_alr = 0, m_bank = 0;
    int m_last = 0; // 0 none, 1 command, 2 address

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int lane(input logic [DW-1:0] v, input bit wide);
        return wide ? int'(v) : int'(v[7:0]);
    endfunction

    function automatic int gap_len(input int kind);
        if (kind != 2) return 0;
        if (m_last == 1) return m_clr + 1;
        if (m_last == 2) return m_alr + 1;
        return 0;
    endfunction

    task automatic set_cfg(input int su, input int st, input int ho, input int hz,
                           input int cg, input int ag, input int bk);
        @(negedge clk);
        cfg_setup = 8'(su); cfg_strobe = 8'(st); cfg_hold = 8'(ho); cfg_hiz = 8'(hz);
        cfg_cle_gap = 4'(cg); cfg_ale_gap = 4'(ag); cfg_bank = 2'(bk);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        m_setup = su; m_strb = st; m_hold = ho; m_hiz = hz;
        m_clr = cg; m_alr = ag; m_bank = bk;
    endtask

    task automatic do_access(input int kind, input logic [DW-1:0] data, input bit wide,
                             input int woff, input bit poke);
        int g, s0, slen, total, wlen, exp_oe, exp_done;
        int i, sfirst, scnt, cle_cnt, ale_cnt, ofirst, dcnt, didx;
        int bad_ce, bad_str, bad_dat, exp_cle, exp_ale;
        logic [DW-1:0] rdv;
        g      = gap_len(kind);
        s0     = g + m_setup + 1;
        wlen   = s0 + woff;
        slen   = imax(m_strb, woff) + 1;
        total  = s0 + slen + m_hold + 1;
        exp_done = s0 + slen;
        if (kind == 2) exp_oe = -1;
        else if (kind == 3) exp_oe = (m_hiz < total) ? m_hiz : -1;
        else exp_oe = 0;
        exp_cle = (kind == 0) ? total - g : 0;
        exp_ale = (kind == 1) ? total - g : 0;
        rdv = 16'($urandom);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_wdata = data; req_wide = wide;
        nand_dq_in = rdv; nand_wait_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        i = 0; sfirst = -1; scnt = 0; cle_cnt = 0; ale_cnt = 0; ofirst = -1;
        dcnt = 0; didx = -1; bad_ce = 0; bad_str = 0; bad_dat = 0;
        while (busy && i < 5000) begin
            if (nand_ce_n != ~(4'b1 << m_bank)) bad_ce++;
            if (nand_cle) cle_cnt++;
            if (nand_ale) ale_cnt++;
            if (!nand_we_n || !nand_re_n) begin
                if (sfirst < 0) sfirst = i;
                scnt++;
                if ((kind == 2) ? !nand_we_n : !nand_re_n) bad_str++;
            end
            if (nand_dq_oe) begin
                if (ofirst < 0) ofirst = i;
                if (int'(nand_dq_out) != lane(data, wide)) bad_dat++;
            end
            if (done) begin dcnt++; didx = i; end
            nand_wait_n = (i >= wlen);
            if (poke && i == 0) begin
                cfg_setup = 8'($urandom_range(1, 9)); cfg_strobe = 8'($urandom_range(1, 9));
                cfg_hold = 8'($urandom_range(1, 9)); cfg_hiz = 8'($urandom_range(1, 9));
                cfg_cle_gap = 4'($urandom); cfg_ale_gap = 4'($urandom);
                cfg_bank = 2'(m_bank + 1);
                cfg_load = 1'b1;
            end
            if (poke && i == 1) cfg_load = 1'b0;
            i++;
            @(negedge clk);
        end
        nand_wait_n = 1'b1;
        check(i == total, "R2,R6 busy length", i, total);
        check(sfirst == s0, (g > 0) ? "R9 gap plus R3 setup" : "R3 setup", sfirst, s0);
        check(scnt == slen, (woff > m_strb) ? "R5 stretched strobe" : "R4 strobe", scnt, slen);
        check(bad_str == 0, "R4 strobe kind", bad_str, 0);
        check(bad_ce == 0, "R12 chip enable", bad_ce, 0);
        check(cle_cnt == exp_cle && ale_cnt == exp_ale, "R8 latch qualifiers",
              cle_cnt * 1000 + ale_cnt, exp_cle * 1000 + exp_ale);
        check(ofirst == exp_oe, "R7 output enable start", ofirst, exp_oe);
        check(bad_dat == 0, wide ? "R6 driven data" : "R11 narrow data", bad_dat, 0);
        if (kind == 2) begin
            check(dcnt == 1 && didx == exp_done, "R10 done timing", didx, exp_done);
            check(int'(rd_data) == lane(rdv, wide), wide ? "R10 read data" : "R11 narrow read",
                  int'(rd_data), lane(rdv, wide));
        end else begin
            check(dcnt == 0, "R10 no done on non-read", dcnt, 0);
        end
        m_last = (kind == 0) ? 1 : (kind == 1) ? 2 : 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 idle flags", {busy, done}, 0);
        check(nand_ce_n == 4'hF && nand_we_n && nand_re_n, "R1 strobes high",
              {nand_ce_n, nand_we_n, nand_re_n}, 63);
        check(!nand_cle && !nand_ale && !nand_dq_oe, "R1 bus quiet",
              {nand_cle, nand_ale, nand_dq_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // defaults: all timing zero, bank 0 (R1, R12)
        do_access(0, 16'hA5C3, 1'b0, 0, 1'b0);
        do_access(2, 16'h0000, 1'b1, 0, 1'b0);
        set_cfg(2, 3, 1, 2, 5, 9, 2);
        do_access(3, 16'hBEEF, 1'b1, 0, 1'b0);
        do_access(3, 16'hBEEF, 1'b0, -2, 1'b0);
        do_access(1, 16'h1234, 1'b1, 0, 1'b0);
        do_access(2, 16'h0000, 1'b1, 0, 1'b0);
        do_access(0, 16'h0070, 1'b0, 0, 1'b0);
        do_access(1, 16'h0055, 1'b0, 0, 1'b0);
        do_access(2, 16'h0000, 1'b0, 9, 1'b0);
        do_access(3, 16'h4321, 1'b1, 0, 1'b0);
        do_access(2, 16'h0000, 1'b1, 6, 1'b0);
        // R13 load during an access is ignored
        do_access(0, 16'h00FF, 1'b1, 0, 1'b1);
        do_access(2, 16'h0000, 1'b1, 0, 1'b0);
        // long hi-z window longer than the access
        set_cfg(0, 1, 0, 200, 0, 0, 3);
        do_access(3, 16'hCAFE, 1'b1, 0, 1'b0);
        // widest fields
        set_cfg(255, 255, 255, 0, 15, 15, 1);
        do_access(3, 16'h9ABC, 1'b1, 3, 1'b0);
        do_access(0, 16'h0011, 1'b1, 300, 1'b0);
        do_access(2, 16'h0000, 1'b0, 0, 1'b0);
        // random mix
        for (int n = 0; n < 80; n++) begin
            if (n % 8 == 0)
                set_cfg($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6),
                        $urandom_range(0, 12), $urandom_range(0, 15), $urandom_range(0, 15),
                        $urandom_range(0, 3));
            do_access($urandom_range(0, 3), 16'($urandom), 1'($urandom),
                      $urandom_range(0, 12) - 3, ($urandom_range(0, 9) == 0));
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule